// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block takes one wide signed two's-complement fixed-point sample per clock and re-expresses it in a narrower signed format. Both formats are fixed when the block is built: total width and fraction bits for the input, and the same pair for the output. The number of dropped fraction bits is the input fraction count minus the output fraction count. The output fraction count must not exceed the input fraction count. The integer range of the output is chosen freely.

Two build-time choices shape the result. The rounding choice decides how the dropped fraction bits are handled. The range choice decides what an out-of-range result turns into. Whichever range choice is built, a flag reports when the correctly rounded value does not fit the output format. The result, the flag and a valid bit come out of one register stage. The stage loads only when the incoming valid bit is set.

Top module: `rq_requant`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous rising clock edge. While `rst_n` is low, `out_valid`, `out_data` and `out_ovf` are all 0.
- R2: In a cycle after one where `in_valid` was low, `out_data` and `out_ovf` keep their previous values.
- R3: With rounding mode truncate (the default), the rounded value is floor(x / 2^D). Here x is the input code and D is the number of dropped bits.
- R4: With rounding mode half-up, the rounded value is floor(x / 2^D + 1/2), so exact ties move toward plus infinity.
- R5: With rounding mode half-even, the rounded value is the nearest output code. An exact tie goes to the even code (bit 0 of the code is 0).
- R6: `out_ovf` is 1 exactly when the rounded value lies outside [-2^(OUT_W-1), 2^(OUT_W-1)-1]. This holds in both range modes. A carry from rounding up past the positive limit sets it.
- R7: With range mode saturate, an overflowing result becomes 2^(OUT_W-1)-1 when positive and -2^(OUT_W-1) when negative.
- R8: With range mode wrap (the default), `out_data` holds the low `OUT_W` bits of the rounded value. With either range mode, an in-range rounded value appears unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | IN_W | Signed input code with IN_FRAC fraction bits |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_data | output | OUT_W | Signed result code with OUT_FRAC fraction bits |
| out_ovf | output | 1 | Rounded value did not fit the output format |

## Verification
The bench aims at exact ties on both sides of zero. A design that applied the half-up rule to ties, or took the parity from the wrong bit, would return a code one step away on half of them. It drives inputs just below, at and just above both range limits, including a tie at the positive limit. A design that tested range before rounding would miss the carry there: it would leave the flag low and pass a wrapped code through the saturating instances. Negative inputs with non-zero dropped bits expose any rounding toward zero instead of toward minus infinity. Idle gaps check that the result holds while no valid sample arrives.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic [1:0] {
        RND_TRUNC     = 2'd0,
        RND_HALF_UP   = 2'd1,
        RND_HALF_EVEN = 2'd2
    } rnd_mode_e;

    typedef enum logic {
        OVF_WRAP = 1'b0,
        OVF_SAT  = 1'b1
    } ovf_mode_e;

endpackage

// File: rtl/rq_round.sv
module rq_round
    import rq_pkg::*;
#(
    parameter int        IN_W     = 24,
    parameter int        DROP     = 8,
    parameter rnd_mode_e RND_MODE = RND_TRUNC
) (
    input  logic [IN_W-1:0]      din,
    output logic [IN_W-DROP:0]   rounded,
    output logic                 bumped
);
    localparam int KW = IN_W - DROP;
    localparam int RW = KW + 1;

    generate
        if (DROP == 0) begin : g_pass
            assign rounded = {din[IN_W-1], din};
            assign bumped  = 1'b0;
        end else begin : g_drop
            logic [KW-1:0] keep;
            logic          half_bit;
            logic          sticky;
            logic          incr_d;

            assign keep     = din[IN_W-1:DROP];
            assign half_bit = din[DROP-1];

            if (DROP > 1) begin : g_sticky
                assign sticky = |din[DROP-2:0];
            end else begin : g_nosticky
                assign sticky = 1'b0;
            end

            always_comb begin
                case (RND_MODE)
                    RND_HALF_UP:   incr_d = half_bit;
                    RND_HALF_EVEN: incr_d = half_bit & (sticky | keep[0]);
                    default:       incr_d = 1'b0;
                endcase
            end

            assign rounded = {keep[KW-1], keep} + RW'(incr_d);
            assign bumped  = incr_d;

            // R4: an upward step is only taken when at least half an LSB was dropped
            always_comb begin
                p_bump_needs_half_r4: assert (!bumped || half_bit)
                    else $error("rounding step without half bit");
            end

            // R3: truncation never steps upward
            if (RND_MODE == RND_TRUNC) begin : g_chk_trunc
                always_comb begin
                    p_trunc_no_bump_r3: assert (!bumped)
                        else $error("truncate mode stepped upward");
                end
            end

            // R5: on an exact tie the result code must come out even
            if (RND_MODE == RND_HALF_EVEN) begin : g_chk_even
                always_comb begin
                    p_tie_even_r5: assert (!(half_bit && !sticky) || !rounded[0])
                        else $error("tie rounded to odd code");
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rq_limit.sv
module rq_limit
    import rq_pkg::*;
#(
    parameter int        RW       = 17,
    parameter int        OUT_W    = 12,
    parameter ovf_mode_e OVF_MODE = OVF_WRAP
) (
    input  logic [RW-1:0]    rounded,
    output logic [OUT_W-1:0] dout,
    output logic             ovf
);
    localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    generate
        if (RW <= OUT_W) begin : g_fits
            assign dout = OUT_W'($signed(rounded));
            assign ovf  = 1'b0;
        end else begin : g_check
            localparam int HW = RW - OUT_W + 1;
            logic [HW-1:0] head;
            logic          fits;

            assign head = rounded[RW-1:OUT_W-1];
            assign fits = (head == {HW{rounded[RW-1]}});

            always_comb begin
                ovf  = !fits;
                dout = rounded[OUT_W-1:0];
                if (!fits && OVF_MODE == OVF_SAT) begin
                    dout = rounded[RW-1] ? MIN_CODE : MAX_CODE;
                end
            end

            // R8: an in-range value leaves the limiter untouched
            always_comb begin
                p_fit_exact_r8: assert (ovf || dout == rounded[OUT_W-1:0])
                    else $error("in-range value altered");
            end
        end
    endgenerate

endmodule

// File: rtl/rq_requant.sv
module rq_requant
    import rq_pkg::*;
#(
    parameter int        IN_W     = 24,
    parameter int        IN_FRAC  = 12,
    parameter int        OUT_W    = 12,
    parameter int        OUT_FRAC = 4,
    parameter rnd_mode_e RND_MODE = RND_TRUNC,
    parameter ovf_mode_e OVF_MODE = OVF_WRAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_ovf
);
    localparam int DROP = IN_FRAC - OUT_FRAC;
    localparam int RW   = IN_W - DROP + 1;

    localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] data;
        logic             ovf;
    } stage_t;

    logic [RW-1:0]    rounded;
    logic             bumped;
    logic [OUT_W-1:0] lim_data;
    logic             lim_ovf;
    stage_t           st_d;
    stage_t           st_q;

    rq_round #(
        .IN_W     (IN_W),
        .DROP     (DROP),
        .RND_MODE (RND_MODE)
    ) u_round (
        .din     (in_data),
        .rounded (rounded),
        .bumped  (bumped)
    );

    rq_limit #(
        .RW       (RW),
        .OUT_W    (OUT_W),
        .OVF_MODE (OVF_MODE)
    ) u_limit (
        .rounded (rounded),
        .dout    (lim_data),
        .ovf     (lim_ovf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = lim_data;
            st_d.ovf  = lim_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_ovf   = st_q.ovf;

    // R1: valid appears one cycle after it is offered, and only then
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("valid not forwarded");

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid)
        else $error("spurious valid");

    // R2: an idle cycle leaves result and flag untouched
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_ovf)))
        else $error("output changed without valid");

    generate
        if (OVF_MODE == OVF_SAT) begin : g_sat_chk
            // R7: a flagged result sits on one of the two rails
            p_sat_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
                out_ovf |-> (out_data == MAX_CODE || out_data == MIN_CODE))
                else $error("flagged result not clamped");
        end
    endgenerate

endmodule

// File: tb/rq_requant_bench.sv
module rq_requant_bench;
    import rq_pkg::*;

    localparam int IN_W     = 24;
    localparam int IN_FRAC  = 12;
    localparam int OUT_W    = 12;
    localparam int OUT_FRAC = 4;
    localparam int DROP     = IN_FRAC - OUT_FRAC;
    localparam longint HALF  = longint'(1) <<< (DROP - 1);
    localparam longint OMAX  = (longint'(1) <<< (OUT_W - 1)) - 1;
    localparam longint OMIN  = -(longint'(1) <<< (OUT_W - 1));

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_data = '0;

    logic             v0, v1, v2;
    logic [OUT_W-1:0] d0, d1, d2;
    logic             o0, o1, o2;

    always #10 clk = ~clk;

    rq_requant #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC))
    u_rq_requant (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v0), .out_data(d0), .out_ovf(o0)
    );

    rq_requant #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC),
                 .RND_MODE(RND_HALF_UP), .OVF_MODE(OVF_SAT))
    u_rq_requant_up (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v1), .out_data(d1), .out_ovf(o1)
    );

    rq_requant #(.IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC),
                 .RND_MODE(RND_HALF_EVEN), .OVF_MODE(OVF_SAT))
    u_rq_requant_even (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v2), .out_data(d2), .out_ovf(o2)
    );

    typedef struct {
        logic [OUT_W-1:0] t_d;
        logic             t_o;
        logic [OUT_W-1:0] u_d;
        logic             u_o;
        logic [OUT_W-1:0] e_d;
        logic             e_o;
    } exp_t;

    exp_t   sb[$];
    exp_t   last;
    bit     have_last = 1'b0;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done = 1'b0;
    logic   iv_edge = 1'b0;

    function automatic longint model_round(longint x, int mode);
        longint fl = x >>> DROP;
        longint fr = x - (fl <<< DROP);
        case (mode)
            1:       return (fr >= HALF) ? fl + 1 : fl;
            2: begin
                if (fr > HALF)  return fl + 1;
                if (fr == HALF) return fl + (fl & 1);
                return fl;
            end
            default: return fl;
        endcase
    endfunction

    function automatic bit model_ovf(longint r);
        return (r > OMAX) || (r < OMIN);
    endfunction

    function automatic logic [OUT_W-1:0] model_sat(longint r);
        if (r > OMAX) return OUT_W'(OMAX);
        if (r < OMIN) return OUT_W'(OMIN);
        return OUT_W'(r);
    endfunction

    task automatic chk(string tag, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(longint x);
        exp_t   e;
        longint rt = model_round(x, 0);
        longint ru = model_round(x, 1);
        longint re = model_round(x, 2);
        e.t_d = OUT_W'(rt);
        e.t_o = model_ovf(rt);
        e.u_d = model_sat(ru);
        e.u_o = model_ovf(ru);
        e.e_d = model_sat(re);
        e.e_o = model_ovf(re);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = IN_W'(x);
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = ~in_data;
        end
    endtask

    always @(posedge clk) iv_edge <= in_valid;

    // monitor / scoreboard
    initial begin
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (!done) begin
                chk("R1 valid latency", OUT_W'(v0), OUT_W'(iv_edge));
                if (v0) begin
                    if (sb.size() == 0) begin
                        chk("R1 valid with nothing pending", OUT_W'(1), OUT_W'(0));
                    end else begin
                        e = sb.pop_front();
                        chk(e.t_o ? "R8 wrap data" : "R3 truncate data", d0, e.t_d);
                        chk("R6 flag truncate/wrap", OUT_W'(o0), OUT_W'(e.t_o));
                        chk(e.u_o ? "R7 saturate data half-up" : "R4 half-up data", d1, e.u_d);
                        chk("R6 flag half-up", OUT_W'(o1), OUT_W'(e.u_o));
                        chk(e.e_o ? "R7 saturate data half-even" : "R5 half-even data", d2, e.e_d);
                        chk("R6 flag half-even", OUT_W'(o2), OUT_W'(e.e_o));
                        chk("R1 valid alignment", OUT_W'({v1, v2}), OUT_W'(2'b11));
                        last      = e;
                        have_last = 1'b1;
                    end
                end else if (have_last) begin
                    chk("R2 hold data", d0, last.t_d);
                    chk("R2 hold flag", OUT_W'(o0), OUT_W'(last.t_o));
                    chk("R2 hold data half-even", d2, last.e_d);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        longint     lim;
        logic [23:0] lfsr;
        lim  = OMAX <<< DROP;
        lfsr = 24'h5A3C91;

        repeat (3) @(negedge clk);
        chk("R1 reset valid", OUT_W'(v0), OUT_W'(0));
        chk("R1 reset data", d0, '0);
        chk("R1 reset flag", OUT_W'(o0), OUT_W'(0));
        rst_n = 1'b1;

        // R3 R4 R5: plain values and ties on both sides of zero
        drive(0);
        drive(256);
        drive(384);
        drive(640);
        drive(-128);
        drive(-384);
        drive(127);
        drive(128);
        drive(129);
        drive(-129);
        drive(-1);
        idle(3);
        // R6 R7 R8: around the positive limit, including a rounding carry
        drive(lim + 127);
        drive(lim + 128);
        drive(lim + 255);
        drive(lim + 256);
        idle(2);
        // negative limit
        drive(OMIN <<< DROP);
        drive((OMIN <<< DROP) - 1);
        drive((OMIN <<< DROP) - 128);
        drive((OMIN <<< DROP) - 129);
        drive(8388607);
        drive(-8388608);
        idle(4);

        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
            if (i % 2 == 0) drive(longint'($signed(lfsr)));
            else            drive(longint'($signed(lfsr)) >>> 4);
            if (i % 17 == 0) idle(2);
        end
        idle(4);

        chk("R1 all results delivered", OUT_W'(sb.size()), '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule